// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control core of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock, divides it down to an integration tick, and steps the external analog switches through a fixed rhythm. The integrator first integrates the unknown input for a fixed number of ticks. It then integrates a reference of opposite sign until the integrator returns through zero. The remaining time of the cycle is spent auto-zeroing. Because the auto-zero phase absorbs whatever the de-integrate phase did not use, every conversion cycle has the same length.

The block samples a single comparator input that reports whether the integrator output is above zero. The level seen after the fixed integration chooses the reference sign and becomes the reading's polarity. The number of de-integrate ticks counted before the comparator flips becomes the magnitude. Magnitude, polarity and an overrange flag are latched together once per cycle, and a one-clock strobe marks the update. The integrator, comparator, reference and switches themselves stay outside the block.

Top module: `dsc_seq`

## Requirements
- R1: At most one of `az_en`, `sig_en`, `ref_pos_en`, `ref_neg_en` is high in any clock. Whenever a switch turns off, all four stay low for at least one tick before another turns on.
- R2: The switch outputs change only on tick boundaries, with one tick every `CLK_DIV` oscillator clocks. `sig_en` stays high for exactly `SIG_TICKS * CLK_DIV` clocks per cycle.
- R3: Consecutive rising edges of `sig_en` are exactly `CYCLE_TICKS * CLK_DIV` clocks apart, whatever the reading.
- R4: While reset is held and right after it is released, `az_en` is 1, the other switches are 0, and `count_o`, `neg_o`, `over_o` and `done_o` are all 0.
- R5: `cmp_i` is sampled at the end of the idle tick that follows signal integration. If it is 1 (integrator above zero), the reading is positive (`neg_o`=0) and `ref_neg_en` drives de-integration. If it is 0, the reading is negative (`neg_o`=1) and `ref_pos_en` drives it.
- R6: `count_o` equals the number of de-integrate ticks completed before the tick at whose end `cmp_i` is first seen different from the sampled polarity. The de-integrate phase ends at that tick.
- R7: If `cmp_i` has not changed after `REF_MAX_TICKS` de-integrate ticks, the phase ends, `over_o` is 1 and `count_o` is `REF_MAX_TICKS-1`. A change seen at exactly tick `REF_MAX_TICKS` is still an in-range reading.
- R8: A zero count keeps its sign. A small positive input reads +0 (`neg_o`=0), and zero or a small negative input reads -0 (`neg_o`=1).
- R9: `count_o`, `neg_o` and `over_o` change only at the clock edge that ends de-integration. `done_o` is high for exactly that one clock, and the outputs hold for the rest of the cycle.
- R10: `az_en` rises one tick after de-integration ends and falls one tick before signal integration starts. It therefore stays high for `(CYCLE_TICKS - SIG_TICKS - 3 - k) * CLK_DIV` clocks, where k is the number of de-integrate ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is above zero |
| az_en | output | 1 | Auto-zero switch select |
| sig_en | output | 1 | Signal-integrate switch select |
| ref_pos_en | output | 1 | Positive-reference de-integrate switch select |
| ref_neg_en | output | 1 | Negative-reference de-integrate switch select |
| count_o | output | $clog2(REF_MAX_TICKS) | Latched reading magnitude |
| neg_o | output | 1 | Latched polarity, 1 = negative |
| over_o | output | 1 | Latched overrange flag |
| done_o | output | 1 | One-clock strobe when the reading updates |

## Verification
The reading, polarity, overrange flag and strobe all appear at the same oscillator edge: the tick edge that ends de-integration. The bench therefore reads them at the falling edge on which `done_o` is first seen high. The de-integrate and integrate run lengths are ready at that same point. The auto-zero length and cycle period are ready only once `sig_en` is next seen high, so those checks wait for that edge. The behavioural integrator moves on falling edges, so the value the design samples at a rising edge has taken exactly the whole ticks before it. This makes each expected count a closed-form ceiling or floor of `SIG_TICKS*vin/vref`, which the bench sweeps across both signs, zero, the full-scale boundary and overrange.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Default timing of one conversion, in integration ticks.
    localparam int DEF_CLK_DIV       = 4;
    localparam int DEF_CYCLE_TICKS   = 4000;
    localparam int DEF_SIG_TICKS     = 1000;
    localparam int DEF_REF_MAX_TICKS = 2000;

    // Sequencer phases; the GAP phases hold all switches open for one tick.
    typedef enum logic [2:0] {
        PH_AZ      = 3'd0,
        PH_GAP_SIG = 3'd1,
        PH_SIG     = 3'd2,
        PH_GAP_REF = 3'd3,
        PH_REF     = 3'd4,
        PH_GAP_AZ  = 3'd5
    } phase_e;

    typedef struct packed {
        logic az;
        logic sig;
        logic ref_pos;
        logic ref_neg;
    } sw_t;

    // Switch selection for a phase; a positive integrator calls for the
    // negative reference during de-integration.
    function automatic sw_t sw_decode(phase_e ph, logic integ_pos);
        sw_t s;
        s = '0;
        case (ph)
            PH_AZ:   s.az  = 1'b1;
            PH_SIG:  s.sig = 1'b1;
            PH_REF: begin
                s.ref_neg = integ_pos;
                s.ref_pos = ~integ_pos;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen #(
    parameter int CLK_DIV = dsc_pkg::DEF_CLK_DIV
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = (div_q == DIV_LAST);
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
    import dsc_pkg::*;
#(
    parameter int CYCLE_TICKS   = DEF_CYCLE_TICKS,
    parameter int SIG_TICKS     = DEF_SIG_TICKS,
    parameter int REF_MAX_TICKS = DEF_REF_MAX_TICKS,
    localparam int CNT_W        = $clog2(REF_MAX_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    output phase_e           phase_o,
    output logic             pos_o,
    output logic             end_o,
    output logic             over_o,
    output logic [CNT_W-1:0] val_o
);
    localparam int CYC_W = $clog2(CYCLE_TICKS);
    localparam int PH_W  = $clog2(max2(SIG_TICKS, REF_MAX_TICKS) + 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLE_TICKS - 1);
    localparam logic [PH_W-1:0]  SIG_LAST = PH_W'(SIG_TICKS - 1);
    localparam logic [PH_W-1:0]  REF_LAST = PH_W'(REF_MAX_TICKS - 1);

    phase_e          phase_q;
    logic [CYC_W-1:0] cyc_q;
    logic [PH_W-1:0]  ph_q;
    logic             pos_q;
    logic             crossed;
    logic             ref_stop;

    // The comparator has left the level it showed after signal integration.
    assign crossed  = (cmp_i != pos_q);
    assign ref_stop = crossed || (ph_q == REF_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_AZ;
            cyc_q   <= '0;
            ph_q    <= '0;
            pos_q   <= 1'b0;
        end else if (tick_i) begin
            cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
            case (phase_q)
                PH_AZ: begin
                    if (cyc_q == CYC_LAST) phase_q <= PH_GAP_SIG;
                end
                PH_GAP_SIG: begin
                    ph_q    <= '0;
                    phase_q <= PH_SIG;
                end
                PH_SIG: begin
                    if (ph_q == SIG_LAST) phase_q <= PH_GAP_REF;
                    else                  ph_q    <= ph_q + 1'b1;
                end
                PH_GAP_REF: begin
                    pos_q   <= cmp_i;
                    ph_q    <= '0;
                    phase_q <= PH_REF;
                end
                PH_REF: begin
                    if (ref_stop) phase_q <= PH_GAP_AZ;
                    else          ph_q    <= ph_q + 1'b1;
                end
                PH_GAP_AZ: phase_q <= PH_AZ;
                default:   phase_q <= PH_AZ;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign pos_o   = pos_q;
    assign end_o   = tick_i && (phase_q == PH_REF) && ref_stop;
    assign over_o  = !crossed;
    // Completed ticks before the current one; saturates at REF_MAX_TICKS-1.
    assign val_o   = CNT_W'(ph_q);
endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             pos_i,
    input  logic             over_i,
    output logic [CNT_W-1:0] count_o,
    output logic             neg_o,
    output logic             over_o,
    output logic             done_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_o <= '0;
            neg_o   <= 1'b0;
            over_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                count_o <= val_i;
                neg_o   <= ~pos_i;
                over_o  <= over_i;
            end
        end
    end
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int CLK_DIV       = DEF_CLK_DIV,
    parameter int CYCLE_TICKS   = DEF_CYCLE_TICKS,
    parameter int SIG_TICKS     = DEF_SIG_TICKS,
    parameter int REF_MAX_TICKS = DEF_REF_MAX_TICKS
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             cmp_i,
    output logic                             az_en,
    output logic                             sig_en,
    output logic                             ref_pos_en,
    output logic                             ref_neg_en,
    output logic [$clog2(REF_MAX_TICKS)-1:0] count_o,
    output logic                             neg_o,
    output logic                             over_o,
    output logic                             done_o
);
    localparam int CNT_W = $clog2(REF_MAX_TICKS);

    logic             tick;
    phase_e           phase;
    logic             pos;
    logic             end_evt;
    logic             over_evt;
    logic [CNT_W-1:0] val;
    sw_t              sw;

    dsc_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    dsc_phase_ctrl #(
        .CYCLE_TICKS   (CYCLE_TICKS),
        .SIG_TICKS     (SIG_TICKS),
        .REF_MAX_TICKS (REF_MAX_TICKS)
    ) ctrl_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .cmp_i   (cmp_i),
        .phase_o (phase),
        .pos_o   (pos),
        .end_o   (end_evt),
        .over_o  (over_evt),
        .val_o   (val)
    );

    dsc_result_reg #(.CNT_W(CNT_W)) res_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (end_evt),
        .val_i   (val),
        .pos_i   (pos),
        .over_i  (over_evt),
        .count_o (count_o),
        .neg_o   (neg_o),
        .over_o  (over_o),
        .done_o  (done_o)
    );

    assign sw         = sw_decode(phase, pos);
    assign az_en      = sw.az;
    assign sig_en     = sw.sig;
    assign ref_pos_en = sw.ref_pos;
    assign ref_neg_en = sw.ref_neg;
endmodule

// File: rtl/dsc_seq_chk.sv
module dsc_seq_chk #(
    parameter int CLK_DIV       = 4,
    parameter int CYCLE_TICKS   = 4000,
    parameter int SIG_TICKS     = 1000,
    parameter int REF_MAX_TICKS = 2000,
    localparam int CNT_W        = $clog2(REF_MAX_TICKS)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             az_en,
    input logic             sig_en,
    input logic             ref_pos_en,
    input logic             ref_neg_en,
    input logic [CNT_W-1:0] count_o,
    input logic             neg_o,
    input logic             over_o,
    input logic             done_o
);
    int  sig_run;
    int  ref_run;
    int  per_cnt;
    logic seen_rise;
    logic ref_on;

    assign ref_on = ref_pos_en || ref_neg_en;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sig_run   <= 0;
            ref_run   <= 0;
            per_cnt   <= 0;
            seen_rise <= 1'b0;
        end else begin
            sig_run <= sig_en ? sig_run + 1 : 0;
            ref_run <= ref_on ? ref_run + 1 : 0;
            if (sig_en && sig_run == 0) begin
                per_cnt   <= 1;
                seen_rise <= 1'b1;
            end else begin
                per_cnt <= per_cnt + 1;
            end
        end
    end

    assert_onehot_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({az_en, sig_en, ref_pos_en, ref_neg_en}));

    assert_gap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(az_en) || $fell(sig_en) || $fell(ref_pos_en) || $fell(ref_neg_en))
        |-> ({az_en, sig_en, ref_pos_en, ref_neg_en} == 4'b0000));

    assert_sig_len_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sig_en) |-> (sig_run == SIG_TICKS * CLK_DIV));

    assert_period_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (sig_en && sig_run == 0 && seen_rise) |-> (per_cnt == CYCLE_TICKS * CLK_DIV));

    assert_ref_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_on |-> (ref_run < REF_MAX_TICKS * CLK_DIV));

    assert_over_count_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        over_o |-> (count_o == CNT_W'(REF_MAX_TICKS - 1)));

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> ($stable(count_o) && $stable(neg_o) && $stable(over_o)));

    assert_done_end_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ($past(ref_on) && !ref_on));
endmodule

bind dsc_seq dsc_seq_chk #(
    .CLK_DIV       (CLK_DIV),
    .CYCLE_TICKS   (CYCLE_TICKS),
    .SIG_TICKS     (SIG_TICKS),
    .REF_MAX_TICKS (REF_MAX_TICKS)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .az_en      (az_en),
    .sig_en     (sig_en),
    .ref_pos_en (ref_pos_en),
    .ref_neg_en (ref_neg_en),
    .count_o    (count_o),
    .neg_o      (neg_o),
    .over_o     (over_o),
    .done_o     (done_o)
);

// File: tb/dsc_seq_tb_top.sv
module dsc_seq_tb_top;
    localparam int DIV   = 4;
    localparam int CYC   = 80;
    localparam int SIG   = 20;
    localparam int RMAX  = 40;
    localparam int CNT_W = $clog2(RMAX);
    localparam int WDOG  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp;
    logic az_en, sig_en, ref_pos_en, ref_neg_en;
    logic [CNT_W-1:0] count_o;
    logic neg_o, over_o, done_o;

    int tests = 0;
    int fails = 0;
    int vin   = 0;
    int vref  = 7;
    int integ = 0;
    int cyc_ctr = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    dsc_seq #(
        .CLK_DIV(DIV), .CYCLE_TICKS(CYC), .SIG_TICKS(SIG), .REF_MAX_TICKS(RMAX)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .cmp_i(cmp),
        .az_en(az_en), .sig_en(sig_en), .ref_pos_en(ref_pos_en), .ref_neg_en(ref_neg_en),
        .count_o(count_o), .neg_o(neg_o), .over_o(over_o), .done_o(done_o)
    );

    // Behavioural integrator, moved on falling edges.
    always @(negedge clk) begin
        if (rst)             integ <= 0;
        else if (az_en)      integ <= 0;
        else if (sig_en)     integ <= integ + vin;
        else if (ref_neg_en) integ <= integ - vref;
        else if (ref_pos_en) integ <= integ + vref;
    end
    assign cmp = (integ > 0);

    // Watchdog
    always @(posedge clk) begin
        cyc_ctr <= cyc_ctr + 1;
        if (cyc_ctr == WDOG) timed_out <= 1'b1;
    end

    // Monitor: run lengths, exclusivity, gaps and hold violations.
    int sig_run = 0, ref_run = 0, az_run = 0, done_run = 0, per_cnt = 0;
    int last_sig = 0, last_ref = 0, last_az = 0, last_done = 0, last_per = 0;
    int viol_onehot = 0, viol_gap = 0, viol_hold = 0;
    bit seen_rise = 1'b0;
    logic [3:0] prev_sw = 4'b0;
    logic prev_sig = 1'b0;
    logic [CNT_W+1:0] prev_out = '0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] sw;
            sw = {az_en, sig_en, ref_pos_en, ref_neg_en};
            if ($countones(sw) > 1) viol_onehot++;
            if (prev_sw != 4'b0 && sw != 4'b0 && sw != prev_sw) viol_gap++;
            prev_sw = sw;
            if ({count_o, neg_o, over_o} != prev_out && !done_o) viol_hold++;
            prev_out = {count_o, neg_o, over_o};
            if (sig_en) sig_run++;
            else if (sig_run != 0) begin last_sig = sig_run; sig_run = 0; end
            if (ref_pos_en || ref_neg_en) ref_run++;
            else if (ref_run != 0) begin last_ref = ref_run; ref_run = 0; end
            if (az_en) az_run++;
            else if (az_run != 0) begin last_az = az_run; az_run = 0; end
            if (done_o) done_run++;
            else if (done_run != 0) begin last_done = done_run; done_run = 0; end
            if (sig_en && !prev_sig) begin
                if (seen_rise) last_per = per_cnt;
                seen_rise = 1'b1;
                per_cnt = 1;
            end else begin
                per_cnt++;
            end
            prev_sig = sig_en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (vin=%0d vref=%0d)", req, act, exp, vin, vref);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o && !timed_out);
        #1;
    endtask

    task automatic wait_sig();
        do @(negedge clk); while (!sig_en && !timed_out);
        #1;
    endtask

    // Ticks at whose end the comparator is first seen changed.
    function automatic int cross_tick(input int v, input int r);
        if (v > 0) return (SIG * v + r - 1) / r;
        else       return (SIG * (-v)) / r + 1;
    endfunction

    task automatic run_one(input int v, input int r, input bit first, inout int prev_k);
        int j, k, ecount, eover;
        vin  = v;
        vref = r;
        if (!first) begin
            wait_sig();
            chk("R10 auto-zero length", last_az, (CYC - SIG - 3 - prev_k) * DIV);
            chk("R3 cycle period", last_per, CYC * DIV);
            chk("R9 done width", last_done, 1);
        end
        wait_done();
        j = cross_tick(v, r);
        eover  = (j > RMAX) ? 1 : 0;
        ecount = eover ? RMAX - 1 : j - 1;
        k      = eover ? RMAX : j;
        chk("R6 count", int'(count_o), ecount);
        chk("R5 polarity", int'(neg_o), (v > 0) ? 0 : 1);
        chk("R7 overrange", int'(over_o), eover);
        chk("R6 de-integrate length", last_ref, k * DIV);
        chk("R2 integrate length", last_sig, SIG * DIV);
        prev_k = k;
    endtask

    initial begin
        int pk;
        pk = 0;
        vin = 3; vref = 7;
        repeat (3) @(posedge clk);
        #1;
        // R4 during reset
        chk("R4 az in reset", int'(az_en), 1);
        chk("R4 switches in reset", int'({sig_en, ref_pos_en, ref_neg_en}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R4 az after reset", int'(az_en), 1);
        chk("R4 outputs after reset", int'({count_o, neg_o, over_o, done_o}), 0);

        // Sweep with a coarse reference: both signs, full-scale edge (14), overrange.
        run_one(3, 7, 1'b1, pk);
        for (int v = -15; v <= 15; v++) begin
            if (timed_out) break;
            run_one(v, 7, 1'b0, pk);
        end
        // R8: zero readings keep their sign.
        for (int v = -3; v <= 3; v++) begin
            if (timed_out) break;
            run_one(v, 25, 1'b0, pk);
        end
        if (!timed_out) begin
            run_one(1, 25, 1'b0, pk);
            chk("R8 +0 count", int'(count_o), 0);
            chk("R8 +0 sign", int'(neg_o), 0);
            run_one(0, 25, 1'b0, pk);
            chk("R8 -0 count", int'(count_o), 0);
            chk("R8 -0 sign", int'(neg_o), 1);
            run_one(14, 7, 1'b0, pk);
            chk("R7 boundary in range", int'(over_o), 0);
            run_one(-14, 7, 1'b0, pk);
            chk("R7 boundary overrange", int'(over_o), 1);
        end

        chk("R1 one-hot violations", viol_onehot, 0);
        chk("R1 gap violations", viol_gap, 0);
        chk("R9 hold violations", viol_hold, 0);
        if (timed_out) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule